// File: doc/BRIEF.md
# Tape Record Stream Framer

This block sits between a record-oriented byte stream and a byte-wide container that stores tape records. Its two directions work on their own. The pack path takes a record from a source and writes it into the container. The record arrives as a stream of beats with a start flag and an end flag, and the first beat also carries the declared byte count. The path writes a length field, the data bytes, a pad byte when the count is odd, and then a copy of the length field. A single request beat writes a file mark.

The unpack path reads the container stream and hands the data bytes to a consumer. The last byte of each record carries an end flag. The path skips pad bytes. It checks the closing length field against the opening one, and it reports file marks and end of tape as beats of their own. Every stream uses valid/ready handshakes. Either side may stall, and no byte is lost or repeated.

The `MAX_LEN` parameter sets the largest record that is passed on. Its default is 2^24 bytes. A longer record is cut to that many bytes in both directions.

Top module: `tape_record_framer`

## Requirements
- R1: For each record the pack path first writes a 4-byte length field, least significant byte first. Its value is the effective length: the declared length, limited to MAX_LEN.
- R2: After the length field the pack path writes the effective-length data bytes in arrival order. If the effective length is odd, it then writes one pad byte of value 0x00. Last it writes the same 4-byte length field again.
- R3: A file-mark request beat (s_mark=1) produces exactly four 0x00 bytes. A record declared with length 0 also produces only four 0x00 bytes, and all of its supplied beats up to the end flag are consumed and discarded.
- R4: Beats past the effective length are accepted and dropped up to and including the beat with the end flag. This covers beats past MAX_LEN and beats past the declared length.
- R5: If the end flag arrives before the effective length is reached, the pack path writes 0x00 bytes for the missing data, and then the pad and the closing length field.
- R6: The unpack path reads a little-endian 4-byte length field, then delivers the data bytes in order. It never delivers the pad byte. The final delivered byte of a record has r_last=1, and every other byte has r_last=0.
- R7: A length field of zero is delivered as one beat with r_mark=1, r_data=0x00 and r_last=0. That beat has r_eot=1 exactly when the item just before it was also a file mark.
- R8: On the final byte of a record, r_ferr=1 when the closing length field differs from the opening one. It is 0 otherwise.
- R9: When the opening length is larger than MAX_LEN, only the first MAX_LEN bytes are delivered. The rest of the record is consumed without being delivered, and the final delivered byte carries r_trunc=1.
- R10: While a valid output is not accepted, that output and all its fields stay unchanged. Under any pattern of stalls on any stream, every byte is transferred exactly once.
- R11: While reset is held, m_valid and r_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Record beat or file-mark request valid |
| s_ready | output | 1 | Record beat accepted |
| s_data | input | 8 | Record data byte |
| s_first | input | 1 | First beat of a record; s_len is valid |
| s_last | input | 1 | Last beat of a record |
| s_mark | input | 1 | File-mark request beat; data ignored |
| s_len | input | 32 | Declared record length on the first beat |
| m_valid | output | 1 | Container output byte valid |
| m_ready | input | 1 | Container output byte accepted |
| m_data | output | 8 | Container output byte |
| c_valid | input | 1 | Container input byte valid |
| c_ready | output | 1 | Container input byte accepted |
| c_data | input | 8 | Container input byte |
| r_valid | output | 1 | Unpacked beat valid |
| r_ready | input | 1 | Unpacked beat accepted |
| r_data | output | 8 | Record data byte |
| r_last | output | 1 | Final byte of a record |
| r_mark | output | 1 | Beat is a file mark |
| r_eot | output | 1 | File mark that follows another file mark |
| r_ferr | output | 1 | Closing length differs from opening length |
| r_trunc | output | 1 | Record was cut to MAX_LEN |

## Verification
A corrupted byte counter or byte index shows up in the container stream within one record. The symptoms are a missing or extra pad byte, a shifted closing length field, or header bytes that run into the data. The next length field then decodes as garbage. On the unpack side, a wrong count moves r_last onto the wrong byte or delivers the pad byte. Both errors are seen on the first beat that differs from the reference model. A stale file-mark history flag appears on the next file-mark beat as a wrong r_eot.

// File: rtl/tape_record_framer.sv
module tape_record_framer #(
  parameter int unsigned MAX_LEN = 32'h0100_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_first,
  input  logic        s_last,
  input  logic        s_mark,
  input  logic [31:0] s_len,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [7:0]  m_data,
  input  logic        c_valid,
  output logic        c_ready,
  input  logic [7:0]  c_data,
  output logic        r_valid,
  input  logic        r_ready,
  output logic [7:0]  r_data,
  output logic        r_last,
  output logic        r_mark,
  output logic        r_eot,
  output logic        r_ferr,
  output logic        r_trunc
);
  localparam logic [31:0] LIMIT = 32'(MAX_LEN);

  function automatic logic [31:0] clamp(input logic [31:0] v);
    return (v > LIMIT) ? LIMIT : v;
  endfunction

  typedef enum logic [2:0] {W_IDLE, W_HDR, W_DATA, W_DROP, W_FILL, W_PAD, W_TRL} wst_t;
  typedef enum logic [2:0] {R_HDR, R_DATA, R_PAD, R_TRL, R_TAIL, R_MARK} rst_t;

  wst_t        w_st;
  logic [31:0] w_len, w_cnt;
  logic [1:0]  w_bi;
  logic        w_mark;
  logic [7:0]  w_len_byte;
  wst_t        w_after;

  assign w_len_byte = 8'(w_len >> {w_bi, 3'b000});
  assign w_after    = w_len[0] ? W_PAD : W_TRL;

  always_comb begin
    s_ready = 1'b0;
    m_valid = 1'b0;
    m_data  = 8'h00;
    case (w_st)
      W_IDLE: s_ready = !s_first || s_mark;
      W_HDR, W_TRL: begin
        m_valid = 1'b1;
        m_data  = w_len_byte;
      end
      W_DATA: begin
        m_valid = s_valid;
        m_data  = s_data;
        s_ready = m_ready;
      end
      W_DROP: s_ready = 1'b1;
      W_FILL, W_PAD: m_valid = 1'b1;
      default: ;
    endcase
  end

  wire s_fire = s_valid && s_ready;
  wire m_fire = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_st   <= W_IDLE;
      w_len  <= '0;
      w_cnt  <= '0;
      w_bi   <= '0;
      w_mark <= 1'b0;
    end else begin
      case (w_st)
        W_IDLE: if (s_valid) begin
          w_bi  <= '0;
          w_cnt <= '0;
          if (s_mark) begin
            w_len  <= '0;
            w_mark <= 1'b1;
            w_st   <= W_HDR;
          end else if (s_first) begin
            w_len  <= clamp(s_len);
            w_mark <= 1'b0;
            w_st   <= W_HDR;
          end
        end
        W_HDR: if (m_fire) begin
          w_bi <= w_bi + 2'd1;
          if (w_bi == 2'd3)
            w_st <= w_mark ? W_IDLE : ((w_len == '0) ? W_DROP : W_DATA);
        end
        W_DATA: if (s_fire) begin
          w_cnt <= w_cnt + 32'd1;
          if (w_cnt + 32'd1 == w_len) w_st <= s_last ? w_after : W_DROP;
          else if (s_last) w_st <= W_FILL;
        end
        W_DROP: if (s_fire && s_last) w_st <= (w_len == '0) ? W_IDLE : w_after;
        W_FILL: if (m_fire) begin
          w_cnt <= w_cnt + 32'd1;
          if (w_cnt + 32'd1 == w_len) w_st <= w_after;
        end
        W_PAD: if (m_fire) w_st <= W_TRL;
        W_TRL: if (m_fire) begin
          w_bi <= w_bi + 2'd1;
          if (w_bi == 2'd3) w_st <= W_IDLE;
        end
        default: w_st <= W_IDLE;
      endcase
    end
  end

  rst_t        r_st;
  logic [31:0] h_len, t_len, r_cnt;
  logic [1:0]  r_bi;
  logic [7:0]  tail;
  logic        prev_mark;
  logic [31:0] r_eff;
  logic        pass;

  assign r_eff = clamp(h_len);
  assign pass  = (r_cnt + 32'd1) < r_eff;

  always_comb begin
    c_ready = 1'b0;
    r_valid = 1'b0;
    r_data  = 8'h00;
    r_last  = 1'b0;
    r_mark  = 1'b0;
    r_eot   = 1'b0;
    r_ferr  = 1'b0;
    r_trunc = 1'b0;
    case (r_st)
      R_HDR, R_PAD, R_TRL: c_ready = 1'b1;
      R_DATA: begin
        if (pass) begin
          r_valid = c_valid;
          r_data  = c_data;
          c_ready = r_ready;
        end else begin
          c_ready = 1'b1;
        end
      end
      R_MARK: begin
        r_valid = 1'b1;
        r_mark  = 1'b1;
        r_eot   = prev_mark;
      end
      R_TAIL: begin
        r_valid = 1'b1;
        r_data  = tail;
        r_last  = 1'b1;
        r_ferr  = t_len != h_len;
        r_trunc = h_len > LIMIT;
      end
      default: ;
    endcase
  end

  wire c_fire = c_valid && c_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_st      <= R_HDR;
      h_len     <= '0;
      t_len     <= '0;
      r_cnt     <= '0;
      r_bi      <= '0;
      tail      <= '0;
      prev_mark <= 1'b0;
    end else begin
      case (r_st)
        R_HDR: if (c_fire) begin
          h_len <= {c_data, h_len[31:8]};
          r_bi  <= r_bi + 2'd1;
          r_cnt <= '0;
          if (r_bi == 2'd3) r_st <= ({c_data, h_len[31:8]} == '0) ? R_MARK : R_DATA;
        end
        R_MARK: if (r_ready) begin
          prev_mark <= 1'b1;
          r_st      <= R_HDR;
        end
        R_DATA: if (c_fire) begin
          if (r_cnt + 32'd1 == r_eff) tail <= c_data;
          r_cnt <= r_cnt + 32'd1;
          if (r_cnt + 32'd1 == h_len) r_st <= h_len[0] ? R_PAD : R_TRL;
        end
        R_PAD: if (c_fire) r_st <= R_TRL;
        R_TRL: if (c_fire) begin
          t_len <= {c_data, t_len[31:8]};
          r_bi  <= r_bi + 2'd1;
          if (r_bi == 2'd3) r_st <= R_TAIL;
        end
        R_TAIL: if (r_ready) begin
          prev_mark <= 1'b0;
          r_st      <= R_HDR;
        end
        default: r_st <= R_HDR;
      endcase
    end
  end
endmodule

// File: rtl/tape_record_framer_chk.sv
module tape_record_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       r_valid,
  input logic       r_ready,
  input logic [7:0] r_data,
  input logic       r_last,
  input logic       r_mark,
  input logic       r_eot,
  input logic       r_ferr,
  input logic       r_trunc
);
  // R10
  m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  // R10
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && !r_ready |=> r_valid && $stable({r_data, r_last, r_mark, r_eot, r_ferr, r_trunc}));

  // R7
  eot_needs_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && r_eot |-> r_mark);

  // R7
  mark_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> $onehot0({r_mark, r_last}));

  // R8 and R9
  flags_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && (r_ferr || r_trunc) |-> r_last);
endmodule

bind tape_record_framer tape_record_framer_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_last(r_last),
  .r_mark(r_mark), .r_eot(r_eot), .r_ferr(r_ferr), .r_trunc(r_trunc)
);

// File: tb/tape_record_framer_tb_top.sv
`timescale 1ns/1ps
module tape_record_framer_tb_top;
  localparam int unsigned MAXL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        s_valid = 1'b0, s_ready, s_first = 1'b0, s_last = 1'b0, s_mark = 1'b0;
  logic [7:0]  s_data = '0;
  logic [31:0] s_len = '0;
  logic        m_valid, m_ready = 1'b0;
  logic [7:0]  m_data;
  logic        c_valid = 1'b0, c_ready;
  logic [7:0]  c_data = '0;
  logic        r_valid, r_ready = 1'b0, r_last, r_mark, r_eot, r_ferr, r_trunc;
  logic [7:0]  r_data;

  tape_record_framer #(.MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_first(s_first),
    .s_last(s_last), .s_mark(s_mark), .s_len(s_len),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .c_valid(c_valid), .c_ready(c_ready), .c_data(c_data),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_last(r_last),
    .r_mark(r_mark), .r_eot(r_eot), .r_ferr(r_ferr), .r_trunc(r_trunc)
  );

  logic [42:0] sq[$];
  logic [7:0]  cq[$];
  logic [7:0]  em[$];
  string       emt[$];
  logic [12:0] er[$];
  string       ert[$];
  int vec = 0;
  int bad = 0;

  function automatic void chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endfunction

  function automatic int unsigned lim(int unsigned v);
    return (v > MAXL) ? MAXL : v;
  endfunction

  task automatic w_rec(int unsigned dl, int n, int base, string tag);
    int unsigned eff = lim(dl);
    for (int i = 0; i < n; i++)
      sq.push_back({dl, 1'b0, 1'(i == n - 1), 1'(i == 0), 8'(base + i)});
    for (int k = 0; k < 4; k++) begin em.push_back(8'(eff >> (8 * k))); emt.push_back("R1"); end
    if (eff == 0) return;
    for (int i = 0; i < int'(eff); i++) begin
      em.push_back((i < n) ? 8'(base + i) : 8'h00);
      emt.push_back(tag);
    end
    if (eff[0]) begin em.push_back(8'h00); emt.push_back("R2"); end
    for (int k = 0; k < 4; k++) begin em.push_back(8'(eff >> (8 * k))); emt.push_back("R2"); end
  endtask

  task automatic w_mark();
    sq.push_back({32'd0, 1'b1, 1'b0, 1'b0, 8'hA5});
    for (int k = 0; k < 4; k++) begin em.push_back(8'h00); emt.push_back("R3"); end
  endtask

  task automatic c_rec(int unsigned h, int unsigned t, int base, string tag);
    int unsigned eff = lim(h);
    for (int k = 0; k < 4; k++) cq.push_back(8'(h >> (8 * k)));
    for (int i = 0; i < int'(h); i++) cq.push_back(8'(base + i));
    if (h[0]) cq.push_back(8'hEE);
    for (int k = 0; k < 4; k++) cq.push_back(8'(t >> (8 * k)));
    for (int i = 0; i < int'(eff); i++) begin
      er.push_back({8'(base + i), 1'(i == int'(eff) - 1), 1'b0, 1'b0,
                    1'((i == int'(eff) - 1) && (t != h)), 1'((i == int'(eff) - 1) && (h > MAXL))});
      ert.push_back(tag);
    end
  endtask

  task automatic c_mark(bit eot);
    for (int k = 0; k < 4; k++) cq.push_back(8'h00);
    er.push_back({8'h00, 1'b0, 1'b1, eot, 1'b0, 1'b0});
    ert.push_back("R7");
  endtask

  initial begin
    bit sf = 0, cf = 0, s_pend, c_pend;
    int cyc = 0;
    w_rec(5, 5, 8'h10, "R2");
    w_rec(4, 4, 8'h20, "R2");
    w_mark();
    w_rec(20, 20, 8'h30, "R4");
    w_rec(6, 3, 8'h50, "R5");
    w_rec(0, 2, 8'h60, "R3");
    w_rec(1, 1, 8'h70, "R2");
    w_rec(8, 10, 8'h80, "R4");
    c_rec(3, 3, 8'h11, "R6");
    c_rec(6, 6, 8'h21, "R6");
    c_mark(1'b0);
    c_mark(1'b1);
    c_rec(2, 3, 8'h41, "R8");
    c_mark(1'b0);
    c_rec(20, 20, 8'h51, "R9");
    c_rec(1, 1, 8'h71, "R6");
    c_mark(1'b0);
    c_mark(1'b1);
    c_mark(1'b1);

    repeat (4) @(negedge clk);
    // R11
    chk("R11", "reset outputs", {m_valid, r_valid}, 2'b00);
    rst_n = 1'b1;

    while (cyc < 20000 && (sq.size() > 0 || cq.size() > 0 || em.size() > 0 || er.size() > 0)) begin
      @(negedge clk);
      if (sf) void'(sq.pop_front());
      if (cf) void'(cq.pop_front());
      s_pend = s_valid && !sf;
      c_pend = c_valid && !cf;
      if (sq.size() > 0 && (s_pend || $urandom_range(0, 3) != 0)) begin
        s_valid = 1'b1;
        {s_len, s_mark, s_last, s_first, s_data} = sq[0];
      end else s_valid = 1'b0;
      if (cq.size() > 0 && (c_pend || $urandom_range(0, 3) != 0)) begin
        c_valid = 1'b1;
        c_data  = cq[0];
      end else c_valid = 1'b0;
      m_ready = $urandom_range(0, 3) != 0;
      r_ready = $urandom_range(0, 3) != 0;
      #1;
      sf = s_valid && s_ready;
      cf = c_valid && c_ready;
      if (m_valid && m_ready) begin
        if (em.size() == 0) chk("R10", "extra container byte", {1'b1, m_data}, 9'h000);
        else begin
          chk(emt[0], "container byte", m_data, em[0]);
          void'(em.pop_front());
          void'(emt.pop_front());
        end
      end
      if (r_valid && r_ready) begin
        if (er.size() == 0) chk("R10", "extra record beat", {1'b1, r_data}, 9'h000);
        else begin
          chk(ert[0], "record beat", {r_data, r_last, r_mark, r_eot, r_ferr, r_trunc}, er[0]);
          void'(er.pop_front());
          void'(ert.pop_front());
        end
      end
      cyc++;
    end
    if (cyc >= 20000) begin
      vec++;
      bad++;
      $display("FAIL R10 watchdog: actual %0d cycles expected fewer than 20000", cyc);
    end
    @(negedge clk);
    s_valid = 1'b0;
    c_valid = 1'b0;
    m_ready = 1'b1;
    r_ready = 1'b1;
    repeat (8) @(negedge clk);
    // R10
    chk("R10", "leftover expected items", em.size() + er.size(), 0);
    // R3
    chk("R3", "outputs idle after drain", {m_valid, r_valid}, 2'b00);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule